// File: doc/BRIEF.md
# Task-Tagged Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address. It holds 32 translation entries per privilege mode. Every valid entry is compared with the presented address and the current task number in the same cycle. A hit returns the matching entry index, the physical address and the attribute bits combinationally.

Each entry records its own page size, from 512 bytes to 4 KB. Address bits that fall inside the page are taken from the virtual address and passed straight to the physical address.

When a translation misses, external logic refills it. The block picks the slot: a free slot if there is one, otherwise the least recently used entry, tracked with a small age counter per entry. Software can drop every entry that belongs to one task, or flush the whole buffer. Two independent banks exist, one for supervisor mode and one for user mode, and the mode input routes every operation to one of them.

Top module: `tlb_dual`

## Requirements
- R1: After reset every entry in both banks is invalid, so any lookup reports hit=0, hit_idx=0, pa=0 and hit_attr=0; these zero values are also reported on any miss.
- R2: A lookup hits only when lookup_en=1, the entry is valid, its stored task number equals tid, and its stored page bits equal va[31:9] on every bit its mask does not exclude. When several entries qualify, hit_idx is the lowest such index.
- R3: The 3-bit page mask is thermometer coded: 000=512 B, 001=1 KB, 011=2 KB, 111=4 KB. Mask bit k drops va[9+k] from the comparison and copies it to pa[9+k]. Otherwise pa[9+k] is stored physical page bit k. pa[31:12] holds stored physical page bits [22:3], and pa[8:0]=va[8:0].
- R4: A refill (fill_en) stores va[31:9], tid, fill_mask, fill_ppn and fill_attr into the lowest-index invalid entry if one exists, otherwise into the entry whose age is 31. The entry is usable from the next clock edge.
- R5: Entry ages always form a permutation of 0..31. A hit or a refill sets the touched entry's age to 0 and adds 1 to every entry younger than the touched entry's previous age.
- R6: A task invalidate (inv_task_en) clears the valid bit of every entry whose task number equals tid and leaves all other entries intact.
- R7: A global invalidate (inv_all_en) clears every valid bit and restores the ages to 0..31 in entry index order.
- R8: mode_sup=1 routes lookup, refill and both invalidates to the supervisor bank and mode_sup=0 to the user bank; the unselected bank neither answers nor changes.
- R9: Within a cycle, global invalidate overrides task invalidate, which overrides refill, which overrides the age update of a lookup hit. The lookup result of that cycle is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sup | input | 1 | 1 selects the supervisor bank, 0 the user bank |
| lookup_en | input | 1 | Lookup request; a hit also updates the ages |
| va | input | 32 | Virtual address for lookup and refill |
| tid | input | 5 | Current task number (lookup, refill, task invalidate) |
| fill_en | input | 1 | Refill request |
| fill_mask | input | 3 | Page-size mask of the refilled entry |
| fill_ppn | input | 23 | Physical page bits [31:9] of the refilled entry |
| fill_attr | input | 5 | Attribute bits of the refilled entry |
| inv_task_en | input | 1 | Invalidate all entries of task tid |
| inv_all_en | input | 1 | Invalidate every entry of the selected bank |
| hit | output | 1 | Lookup hit |
| hit_idx | output | 5 | Index of the hitting entry |
| pa | output | 32 | Translated physical address |
| hit_attr | output | 5 | Attribute bits of the hitting entry |

## Verification
The age update from a lookup hit and a refill can land in the same cycle. The bench provokes this by refilling an address that already hits. It expects the hit to be reported with its old index. Only the refill victim should become the youngest entry, and later refills are used to judge this by where they land. In the same way, the bench issues a task invalidate together with a refill. A following lookup of the refilled address must miss, because the refill was dropped. The bench's reference model applies these priorities and predicts every hit, index and address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 9;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int PPN_W  = VPN_W;
    localparam int TID_W  = 5;
    localparam int ATTR_W = 5;
    localparam int MASK_W = 3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [TID_W-1:0]  tid;
        logic [MASK_W-1:0] mask;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N = 32
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDX_W = $clog2(N);

    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_entry_t [ENTRIES-1:0] ent,
    input  logic [ENTRIES-1:0]       valid,
    input  logic                     en,
    input  logic [VPN_W-1:0]         vpn,
    input  logic [TID_W-1:0]         tid,
    output logic [ENTRIES-1:0]       match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] care;
        always_comb begin
            care = {VPN_W{1'b1}};
            care[MASK_W-1:0] = ~ent[g].mask;
        end
        assign match[g] = en & valid[g] & (ent[g].tid == tid)
                        & (((ent[g].vpn ^ vpn) & care) == '0);
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       touch_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_idx,
    input  logic                       restart,
    output logic [$clog2(ENTRIES)-1:0] oldest_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_state_t;

    lru_state_t s_d, s_q;
    logic [IDX_W-1:0]   old_age;
    logic [ENTRIES-1:0] oldest_vec;
    logic               oldest_found;

    always_comb begin
        s_d     = s_q;
        old_age = s_q.age[touch_idx];
        if (restart) begin
            for (int i = 0; i < ENTRIES; i++) s_d.age[i] = IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)      s_d.age[i] = '0;
                else if (s_q.age[i] < old_age)   s_d.age[i] = s_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) s_q.age[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            oldest_vec[i] = (s_q.age[i] == IDX_W'(ENTRIES - 1));
    end

    tlb_prio_enc #(.N(ENTRIES)) u_oldest (
        .req  (oldest_vec),
        .found(oldest_found),
        .idx  (oldest_idx)
    );

    p_single_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1 && oldest_found);

    p_touch_youngest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en && !restart |=> s_q.age[$past(touch_idx)] == '0);

    p_restart_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> s_q.age[ENTRIES-1] == IDX_W'(ENTRIES - 1) && s_q.age[0] == '0);
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lookup_en,
    input  logic [VA_W-1:0]            va,
    input  logic [TID_W-1:0]           tid,
    input  logic                       fill_en,
    input  logic [MASK_W-1:0]          fill_mask,
    input  logic [PPN_W-1:0]           fill_ppn,
    input  logic [ATTR_W-1:0]          fill_attr,
    input  logic                       inv_task_en,
    input  logic                       inv_all_en,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    output logic [VA_W-1:0]            pa,
    output logic [ATTR_W-1:0]          hit_attr
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [ENTRIES-1:0]       valid;
    } bank_state_t;

    bank_state_t s_d, s_q;

    logic [ENTRIES-1:0] match;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_sel;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   oldest_idx;
    logic [IDX_W-1:0]   victim;
    logic               do_fill;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    tlb_entry_t         sel;
    tlb_entry_t         new_ent;

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ent  (s_q.ent),
        .valid(s_q.valid),
        .en   (lookup_en),
        .vpn  (va[VA_W-1:PG_LSB]),
        .tid  (tid),
        .match(match)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_hit_enc (
        .req  (match),
        .found(hit_any),
        .idx  (hit_sel)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_free_enc (
        .req  (~s_q.valid),
        .found(free_any),
        .idx  (free_idx)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .restart   (inv_all_en),
        .oldest_idx(oldest_idx)
    );

    assign victim  = free_any ? free_idx : oldest_idx;
    assign do_fill = fill_en && !inv_all_en && !inv_task_en;

    // refill beats the age update of a hit; invalidates beat both
    always_comb begin
        touch_en  = 1'b0;
        touch_idx = hit_sel;
        if (!inv_all_en && !inv_task_en) begin
            if (fill_en) begin
                touch_en  = 1'b1;
                touch_idx = victim;
            end else if (hit_any) begin
                touch_en  = 1'b1;
            end
        end
    end

    always_comb begin
        new_ent.vpn  = va[VA_W-1:PG_LSB];
        new_ent.tid  = tid;
        new_ent.mask = fill_mask;
        new_ent.ppn  = fill_ppn;
        new_ent.attr = fill_attr;
    end

    always_comb begin
        s_d = s_q;
        if (inv_all_en) begin
            s_d.valid = '0;
        end else if (inv_task_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (s_q.ent[i].tid == tid) s_d.valid[i] = 1'b0;
        end else if (fill_en) begin
            s_d.ent[victim]   = new_ent;
            s_d.valid[victim] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        sel      = s_q.ent[hit_sel];
        hit      = hit_any;
        hit_idx  = '0;
        pa       = '0;
        hit_attr = '0;
        if (hit_any) begin
            hit_idx  = hit_sel;
            hit_attr = sel.attr;
            pa[VA_W-1:PG_LSB+MASK_W] = sel.ppn[PPN_W-1:MASK_W];
            for (int k = 0; k < MASK_W; k++)
                pa[PG_LSB+k] = sel.mask[k] ? va[PG_LSB+k] : sel.ppn[k];
            pa[PG_LSB-1:0] = va[PG_LSB-1:0];
        end
    end

    p_hit_is_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match[hit_idx] && lookup_en);

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill |=> s_q.valid[$past(victim)]);

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all_en |=> s_q.valid == '0);

    p_free_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_fill && free_any |=> $past(s_q.valid[victim]) == 1'b0);
endmodule

// File: rtl/tlb_dual.sv
module tlb_dual
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int BANKS   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_sup,
    input  logic                       lookup_en,
    input  logic [VA_W-1:0]            va,
    input  logic [TID_W-1:0]           tid,
    input  logic                       fill_en,
    input  logic [MASK_W-1:0]          fill_mask,
    input  logic [PPN_W-1:0]           fill_ppn,
    input  logic [ATTR_W-1:0]          fill_attr,
    input  logic                       inv_task_en,
    input  logic                       inv_all_en,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    output logic [VA_W-1:0]            pa,
    output logic [ATTR_W-1:0]          hit_attr
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [BANKS-1:0]             b_hit;
    logic [BANKS-1:0][IDX_W-1:0]  b_idx;
    logic [BANKS-1:0][VA_W-1:0]   b_pa;
    logic [BANKS-1:0][ATTR_W-1:0] b_attr;
    logic [BANKS-1:0]             b_sel;

    // bank 1 serves supervisor mode, bank 0 user mode
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign b_sel[b] = (b == 1) ? mode_sup : !mode_sup;
        tlb_bank #(.ENTRIES(ENTRIES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lookup_en  (lookup_en   & b_sel[b]),
            .va         (va),
            .tid        (tid),
            .fill_en    (fill_en     & b_sel[b]),
            .fill_mask  (fill_mask),
            .fill_ppn   (fill_ppn),
            .fill_attr  (fill_attr),
            .inv_task_en(inv_task_en & b_sel[b]),
            .inv_all_en (inv_all_en  & b_sel[b]),
            .hit        (b_hit[b]),
            .hit_idx    (b_idx[b]),
            .pa         (b_pa[b]),
            .hit_attr   (b_attr[b])
        );
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        pa       = '0;
        hit_attr = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (b_sel[b]) begin
                hit      = b_hit[b];
                hit_idx  = b_idx[b];
                pa       = b_pa[b];
                hit_attr = b_attr[b];
            end
        end
    end

    p_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_hit));

    p_idle_bank_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sup |-> !b_hit[0]);
endmodule

// File: tb/tlb_dual_test.sv
module tlb_dual_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_sup, lookup_en, fill_en, inv_task_en, inv_all_en;
    logic [31:0] va;
    logic [4:0]  tid;
    logic [2:0]  fill_mask;
    logic [22:0] fill_ppn;
    logic [4:0]  fill_attr;
    logic        hit;
    logic [4:0]  hit_idx;
    logic [31:0] pa;
    logic [4:0]  hit_attr;

    always #5 clk = ~clk;

    tlb_dual uut (
        .clk(clk), .rst_n(rst_n), .mode_sup(mode_sup), .lookup_en(lookup_en),
        .va(va), .tid(tid), .fill_en(fill_en), .fill_mask(fill_mask),
        .fill_ppn(fill_ppn), .fill_attr(fill_attr), .inv_task_en(inv_task_en),
        .inv_all_en(inv_all_en), .hit(hit), .hit_idx(hit_idx), .pa(pa),
        .hit_attr(hit_attr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model, per bank
    bit          m_vld [2][32];
    logic [22:0] m_vpn [2][32];
    logic [4:0]  m_tid [2][32];
    logic [2:0]  m_msk [2][32];
    logic [22:0] m_ppn [2][32];
    logic [4:0]  m_atr [2][32];
    int          m_age [2][32];

    logic [42:0] exp_q[$];
    string       tag_q[$];

    function automatic void model_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 32; i++) begin
                m_vld[b][i] = 0; m_age[b][i] = i;
            end
    endfunction

    function automatic void model_touch(int b, int t);
        int old;
        old = m_age[b][t];
        for (int i = 0; i < 32; i++)
            if (i == t) m_age[b][i] = 0;
            else if (m_age[b][i] < old) m_age[b][i] = m_age[b][i] + 1;
    endfunction

    task automatic cyc(input bit m, input bit le, input logic [31:0] a,
                       input logic [4:0] t, input bit fe, input logic [2:0] mk,
                       input logic [22:0] pp, input logic [4:0] at,
                       input bit it, input bit ia, input string tag);
        int b, idx, vic;
        bit h, ok;
        logic [31:0] epa;
        logic [4:0]  eat;
        @(negedge clk);
        #1;
        mode_sup = m; lookup_en = le; va = a; tid = t; fill_en = fe;
        fill_mask = mk; fill_ppn = pp; fill_attr = at;
        inv_task_en = it; inv_all_en = ia;
        b = m ? 1 : 0;
        h = 0; idx = 0; epa = '0; eat = '0;
        if (le) begin
            for (int i = 31; i >= 0; i--) begin
                ok = m_vld[b][i] && m_tid[b][i] == t;
                for (int k = 0; k < 23; k++)
                    if (!(k < 3 && m_msk[b][i][k]) && m_vpn[b][i][k] != a[9+k]) ok = 0;
                if (ok) begin h = 1; idx = i; end
            end
        end
        if (h) begin
            epa[31:12] = m_ppn[b][idx][22:3];
            for (int k = 0; k < 3; k++)
                epa[9+k] = m_msk[b][idx][k] ? a[9+k] : m_ppn[b][idx][k];
            epa[8:0] = a[8:0];
            eat = m_atr[b][idx];
        end
        exp_q.push_back({h, 5'(idx), epa, eat});
        tag_q.push_back(tag);
        if (ia) begin
            for (int i = 0; i < 32; i++) begin m_vld[b][i] = 0; m_age[b][i] = i; end
        end else if (it) begin
            for (int i = 0; i < 32; i++) if (m_tid[b][i] == t) m_vld[b][i] = 0;
        end else if (fe) begin
            vic = -1;
            for (int i = 31; i >= 0; i--) if (!m_vld[b][i]) vic = i;
            if (vic < 0) for (int i = 0; i < 32; i++) if (m_age[b][i] == 31) vic = i;
            m_vld[b][vic] = 1; m_vpn[b][vic] = a[31:9]; m_tid[b][vic] = t;
            m_msk[b][vic] = mk; m_ppn[b][vic] = pp; m_atr[b][vic] = at;
            model_touch(b, vic);
        end else if (h) begin
            model_touch(b, idx);
        end
    endtask

    task automatic look(input bit m, input logic [31:0] a, input logic [4:0] t, input string tag);
        cyc(m, 1, a, t, 0, 3'b0, 23'b0, 5'b0, 0, 0, tag);
    endtask

    task automatic fill(input bit m, input logic [31:0] a, input logic [4:0] t,
                        input logic [2:0] mk, input string tag);
        cyc(m, 0, a, t, 1, mk, 23'(a[31:12] * 3 + 5), a[16:12] ^ 5'h15, 0, 0, tag);
    endtask

    function automatic logic [31:0] mkva(int k, logic [11:0] low);
        return 32'h4000_0000 + (32'(k) << 12) + 32'(low);
    endfunction

    function automatic logic [4:0] tidof(int k);
        return (k < 4) ? 5'd3 : 5'(k % 4);
    endfunction

    // monitor: compares outputs late in the low clock phase
    initial begin
        logic [42:0] e;
        string tg;
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({hit, hit_idx, pa, hit_attr} !== e) begin
                    fails++;
                    $display("FAIL %s: got hit=%0b idx=%0d pa=%h attr=%h exp hit=%0b idx=%0d pa=%h attr=%h",
                             tg, hit, hit_idx, pa, hit_attr, e[42], e[41:37], e[36:5], e[4:0]);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_sup = 0; lookup_en = 0; va = '0; tid = '0; fill_en = 0;
        fill_mask = '0; fill_ppn = '0; fill_attr = '0; inv_task_en = 0; inv_all_en = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        look(0, mkva(0, 0), 3, "R1 user miss after reset");
        look(1, mkva(0, 0), 3, "R1 supervisor miss after reset");

        // one entry per page size, slots taken in index order
        fill(0, mkva(0, 0), 3, 3'b000, "R4 fill");
        fill(0, mkva(1, 0), 3, 3'b001, "R4 fill");
        fill(0, mkva(2, 0), 3, 3'b011, "R4 fill");
        fill(0, mkva(3, 0), 3, 3'b111, "R4 fill");
        for (int k = 0; k < 4; k++) look(0, mkva(k, 0), 3, "R4 index order");
        cyc(0, 0, mkva(0, 0), 3, 0, 3'b0, 23'b0, 5'b0, 0, 0, "R2 lookup_en low");
        look(0, mkva(3, 12'hA5C), 3, "R3 4KB passthrough");
        look(0, mkva(2, 12'h6F0), 3, "R3 2KB passthrough");
        look(0, mkva(2, 12'hE00), 3, "R3 2KB bit11 compared");
        look(0, mkva(1, 12'h3FF), 3, "R3 1KB passthrough");
        look(0, mkva(1, 12'h400), 3, "R3 1KB bit10 compared");
        look(0, mkva(0, 12'h1FF), 3, "R3 512B passthrough");
        look(0, mkva(0, 12'h200), 3, "R3 512B bit9 compared");
        look(0, mkva(0, 0), 4, "R2 task mismatch");
        look(1, mkva(0, 0), 3, "R8 other bank empty");

        fill(1, mkva(100, 0), 7, 3'b000, "R8 supervisor fill");
        look(1, mkva(100, 0), 7, "R8 supervisor hit");
        look(0, mkva(100, 0), 7, "R8 user bank unaffected");

        for (int k = 4; k < 32; k++) fill(0, mkva(k, 0), tidof(k), 3'b000, "R4 fill to full");
        look(0, mkva(31, 0), tidof(31), "R4 last slot");

        // LRU replacement once full
        for (int r = 0; r < 12; r++) begin
            look(0, mkva((r * 7) % 32, 0), tidof((r * 7) % 32), "R5 touch");
            fill(0, mkva(40 + r, 0), 2, 3'b000, "R5 lru victim fill");
            look(0, mkva(40 + r, 0), 2, "R5 refill hit at victim");
            look(0, mkva(r, 0), tidof(r), "R5 possibly evicted");
        end

        // refill while the same address already hits
        cyc(0, 1, mkva(41, 0), 2, 1, 3'b000, 23'h1234, 5'h0A, 0, 0, "R9 fill during hit");
        for (int r = 0; r < 4; r++) begin
            fill(0, mkva(60 + r, 0), 1, 3'b000, "R9 later fill");
            look(0, mkva(41, 0), 2, "R9 duplicate lowest index");
        end

        cyc(0, 0, 32'h0, 1, 0, 3'b0, 23'b0, 5'b0, 1, 0, "R6 task invalidate");
        for (int k = 0; k < 32; k++) look(0, mkva(k, 0), tidof(k), "R6 after task invalidate");
        for (int r = 0; r < 4; r++) look(0, mkva(60 + r, 0), 1, "R6 task 1 gone");
        fill(0, mkva(70, 0), 9, 3'b000, "R6 freed slot reuse");
        look(0, mkva(70, 0), 9, "R6 freed slot reuse");

        cyc(0, 0, mkva(71, 0), 2, 1, 3'b000, 23'h55, 5'h1, 1, 0, "R9 invalidate beats fill");
        look(0, mkva(71, 0), 2, "R9 dropped fill misses");
        look(0, mkva(70, 0), 9, "R9 other task kept");

        cyc(0, 0, 32'h0, 0, 1, 3'b0, 23'h1, 5'h1, 0, 1, "R7 global invalidate");
        look(0, mkva(70, 0), 9, "R7 miss after flush");
        look(0, mkva(5, 0), tidof(5), "R7 miss after flush");
        look(1, mkva(100, 0), 7, "R8 supervisor survives user flush");

        for (int k = 0; k < 34; k++) fill(0, mkva(200 + k, 0), 4, 3'b001, "R7 refill after flush");
        for (int k = 0; k < 34; k++) look(0, mkva(200 + k, 12'h200), 4, "R7 order after flush");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule